// File: doc/BRIEF.md
# Serial Mouse Packet Encoder

This block turns one mouse report into a fixed five-byte packet that is pushed, one byte per handshake, into the receive queue of a serial channel. A report carries signed X and Y motion plus the state of the left, middle and right buttons, and is offered with a valid/ready pair. The encoder latches the whole report when it accepts it. It then streams a sync byte that carries the buttons, an X byte, a Y byte and two trailing zero motion bytes.

Motion arrives as a wide two's-complement value. It is saturated to the symmetric range -127..+127 before it is sent. Y is negated first, so that upward motion on the wire is positive. The encoder holds one report at a time and takes no new report until the last byte of the current packet has been queued.

Top module: `mse_pkt_enc`

## Requirements
- R1: After reset, `out_valid` is 0 and `evt_ready` is 1.
- R2: Byte 0 of a packet is the sync byte. Bits 7..3 are 1,0,0,0,0. Bit 2 is the inverse of the left button, bit 1 the inverse of the middle button and bit 0 the inverse of the right button, so a report with no button pressed gives 0x87.
- R3: Byte 1 is X motion saturated to -127..127, in 8-bit two's complement (values above 127 give 0x7F, values below -127 give 0x81).
- R4: Byte 2 is the negated Y input, saturated the same way as R3.
- R5: Bytes 3 and 4 are 0x00.
- R6: Each accepted report yields exactly five bytes in the order of R2 to R5, after which `out_valid` falls.
- R7: `evt_ready` is 0 while a packet is in flight. A report offered then has no effect on the bytes of the current packet.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` holds its value.
- R9: `evt_ready` returns to 1 in the cycle after the fifth byte is accepted, and the next report is then taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | Report offered |
| evt_ready | output | 1 | Encoder can take a report |
| evt_dx | input | MOT_W | Signed X motion |
| evt_dy | input | MOT_W | Signed Y motion (positive is downward) |
| evt_left | input | 1 | Left button pressed |
| evt_mid | input | 1 | Middle button pressed |
| evt_right | input | 1 | Right button pressed |
| out_valid | output | 1 | Packet byte available |
| out_ready | input | 1 | Queue takes the byte |
| out_data | output | 8 | Packet byte |

## Verification
The assertions assume that packet boundaries can be found by counting output handshakes from reset. This holds only if no byte is dropped or duplicated, and the checker's own counter recovers the byte index on that basis. They also assume that the queue side may stall for any length of time. Stalls are therefore not bounded by any property. The stimulus sweeps every X and every Y value of the default 10-bit width, cycling through all button combinations. It stalls the queue on a fraction of the packets and offers stray reports during those stalls.

// File: rtl/mse_pkt_pkg.sv
package mse_pkt_pkg;
    typedef logic [7:0] byte_t;

    localparam int    SAT_MAG   = 127;
    localparam logic [4:0] SYNC_TAG = 5'b10000;
    localparam byte_t PAD_BYTE  = 8'h00;
    localparam int    HEAD_LEN  = 3;
endpackage

// File: rtl/mse_clamp.sv
module mse_clamp #(
    parameter int IN_W   = 10,
    parameter bit NEGATE = 1'b0
) (
    input  logic signed [IN_W-1:0] raw_i,
    output mse_pkt_pkg::byte_t     byte_o
);
    localparam int EXT_W = IN_W + 1;
    localparam logic signed [EXT_W-1:0] HI = EXT_W'(mse_pkt_pkg::SAT_MAG);
    localparam logic signed [EXT_W-1:0] LO = -HI;

    logic signed [EXT_W-1:0] ext;
    logic signed [EXT_W-1:0] val;

    assign ext = {raw_i[IN_W-1], raw_i};

    generate
        if (NEGATE) begin : g_neg
            assign val = -ext;
        end else begin : g_pos
            assign val = ext;
        end
    endgenerate

    always_comb begin
        if (val > HI)      byte_o = HI[7:0];
        else if (val < LO) byte_o = LO[7:0];
        else               byte_o = val[7:0];
    end
endmodule

// File: rtl/mse_sync_byte.sv
module mse_sync_byte (
    input  logic               left_i,
    input  logic               mid_i,
    input  logic               right_i,
    output mse_pkt_pkg::byte_t sync_o
);
    always_comb begin
        sync_o = {mse_pkt_pkg::SYNC_TAG, ~left_i, ~mid_i, ~right_i};
    end
endmodule

// File: rtl/mse_pkt_enc.sv
module mse_pkt_enc #(
    parameter int MOT_W   = 10,
    parameter int NUM_PAD = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_valid,
    output logic             evt_ready,
    input  logic [MOT_W-1:0] evt_dx,
    input  logic [MOT_W-1:0] evt_dy,
    input  logic             evt_left,
    input  logic             evt_mid,
    input  logic             evt_right,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [7:0]       out_data
);
    import mse_pkt_pkg::*;

    localparam int PKT_LEN = HEAD_LEN + NUM_PAD;
    localparam int IDX_W   = $clog2(PKT_LEN);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PKT_LEN - 1);

    typedef struct packed {
        logic             busy;
        logic [IDX_W-1:0] idx;
        byte_t            sync;
        byte_t            mx;
        byte_t            my;
    } enc_state_t;

    enc_state_t st_q, st_d;
    byte_t      sync_w, mx_w, my_w;
    logic       take_evt, take_byte;

    mse_sync_byte sync_i (
        .left_i  (evt_left),
        .mid_i   (evt_mid),
        .right_i (evt_right),
        .sync_o  (sync_w)
    );

    mse_clamp #(.IN_W(MOT_W), .NEGATE(1'b0)) clamp_x_i (
        .raw_i  (evt_dx),
        .byte_o (mx_w)
    );

    mse_clamp #(.IN_W(MOT_W), .NEGATE(1'b1)) clamp_y_i (
        .raw_i  (evt_dy),
        .byte_o (my_w)
    );

    assign evt_ready = ~st_q.busy;
    assign out_valid = st_q.busy;
    assign take_evt  = evt_valid & ~st_q.busy;
    assign take_byte = out_ready & st_q.busy;

    always_comb begin
        case (st_q.idx)
            IDX_W'(0): out_data = st_q.sync;
            IDX_W'(1): out_data = st_q.mx;
            IDX_W'(2): out_data = st_q.my;
            default:   out_data = PAD_BYTE;
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (take_evt) begin
            st_d.busy = 1'b1;
            st_d.idx  = '0;
            st_d.sync = sync_w;
            st_d.mx   = mx_w;
            st_d.my   = my_w;
        end else if (take_byte) begin
            if (st_q.idx == LAST_IDX) begin
                st_d.busy = 1'b0;
                st_d.idx  = '0;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/mse_pkt_enc_chk.sv
module mse_pkt_enc_chk #(
    parameter int PKT_LEN = 5
) (
    input logic       clk,
    input logic       rst_n,
    input logic       evt_valid,
    input logic       evt_ready,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_data
);
    localparam int CW = $clog2(PKT_LEN);
    logic [CW-1:0] pos_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (out_valid && out_ready) begin
            pos_q <= (pos_q == CW'(PKT_LEN - 1)) ? '0 : pos_q + 1'b1;
        end
    end

    p_ready_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(evt_ready && out_valid));

    p_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_ready) |=> (out_valid && pos_q == '0));

    p_sync_tag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && pos_q == '0) |-> (out_data[7:3] == 5'b10000));

    p_x_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && pos_q == CW'(1)) |-> (out_data != 8'h80));

    p_y_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && pos_q == CW'(2)) |-> (out_data != 8'h80));

    p_pad_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && pos_q >= CW'(3)) |-> (out_data == 8'h00));

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && pos_q == CW'(PKT_LEN - 1)) |=> evt_ready);
endmodule

bind mse_pkt_enc mse_pkt_enc_chk #(.PKT_LEN(PKT_LEN)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_valid (evt_valid),
    .evt_ready (evt_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
);

// File: tb/mse_pkt_enc_tb.sv
module mse_pkt_enc_tb_top;
    localparam int MOT_W = 10;
    localparam int NPKT  = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             evt_valid = 1'b0;
    logic             evt_ready;
    logic [MOT_W-1:0] evt_dx = '0;
    logic [MOT_W-1:0] evt_dy = '0;
    logic             evt_left = 1'b0;
    logic             evt_mid = 1'b0;
    logic             evt_right = 1'b0;
    logic             out_valid;
    logic             out_ready = 1'b0;
    logic [7:0]       out_data;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    mse_pkt_enc #(.MOT_W(MOT_W), .NUM_PAD(2)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_valid (evt_valid),
        .evt_ready (evt_ready),
        .evt_dx    (evt_dx),
        .evt_dy    (evt_dy),
        .evt_left  (evt_left),
        .evt_mid   (evt_mid),
        .evt_right (evt_right),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data)
    );

    function automatic logic [7:0] sat8(input int v);
        if (v > 127)  return 8'h7f;
        if (v < -127) return 8'h81;
        return v[7:0];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // One report: dx, dy, buttons {left,mid,right}, stall cycles per byte
    task automatic run_pkt(input int dx, input int dy, input logic [2:0] b, input int stall);
        logic [7:0] exp_b [NPKT];
        exp_b[0] = {5'b10000, ~b[2], ~b[1], ~b[0]};
        exp_b[1] = sat8(dx);
        exp_b[2] = sat8(-dy);
        exp_b[3] = 8'h00;
        exp_b[4] = 8'h00;
        check("R9 ready before report", {31'd0, evt_ready}, 32'd1);
        evt_valid = 1'b1;
        evt_dx    = MOT_W'(dx);
        evt_dy    = MOT_W'(dy);
        {evt_left, evt_mid, evt_right} = b;
        @(negedge clk);
        evt_valid = 1'b0;
        check("R7 busy after accept", {31'd0, evt_ready}, 32'd0);
        for (int k = 0; k < NPKT; k++) begin
            out_ready = 1'b0;
            for (int s = 0; s < stall; s++) begin
                // stray report while busy must be ignored
                evt_valid = 1'b1;
                evt_dx    = MOT_W'(dx + 37);
                evt_dy    = MOT_W'(dy - 91);
                {evt_left, evt_mid, evt_right} = ~b;
                check("R8 valid held", {31'd0, out_valid}, 32'd1);
                check(k == 0 ? "R2 sync byte (stall)" : k == 1 ? "R3 x byte (stall)" :
                      k == 2 ? "R4 y byte (stall)" : "R5 pad byte (stall)",
                      {24'd0, out_data}, {24'd0, exp_b[k]});
                @(negedge clk);
                evt_valid = 1'b0;
            end
            out_ready = 1'b1;
            check("R6 byte present", {31'd0, out_valid}, 32'd1);
            check(k == 0 ? "R2 sync byte" : k == 1 ? "R3 x byte" :
                  k == 2 ? "R4 y byte" : "R5 pad byte",
                  {24'd0, out_data}, {24'd0, exp_b[k]});
            @(negedge clk);
        end
        out_ready = 1'b0;
        check("R6 five bytes only", {31'd0, out_valid}, 32'd0);
        check("R9 ready after last", {31'd0, evt_ready}, 32'd1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 out_valid at reset", {31'd0, out_valid}, 32'd0);
        check("R1 evt_ready at reset", {31'd0, evt_ready}, 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 out_valid after reset", {31'd0, out_valid}, 32'd0);
        // X sweep, buttons cycling, queue never stalls
        for (int v = -512; v < 512; v++)
            run_pkt(v, 0, 3'(v), 0);
        // Y sweep with stalls every fourth report
        for (int v = -512; v < 512; v++)
            run_pkt(3, v, ~3'(v), ((v & 3) == 0) ? 2 : 0);
        // all button combinations at the saturation edges with long stalls
        for (int bb = 0; bb < 8; bb++) begin
            run_pkt(127, -127, 3'(bb), 3);
            run_pkt(-128, 128, 3'(bb), 1);
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule